// File: doc/BRIEF.md
# Square Root Sequencing Controller

This block is the small control state machine that sits beside an iterative square root unit and produces the three control strobes that unit needs. A single-cycle pulse on `run` launches one calculation. The controller then issues a one-cycle `start` to capture the operand. It lets the unit iterate for one clock per result bit and finally gives a one-cycle `stop` that loads the result register. `busy` frames the whole operation so that surrounding logic knows when a new request can be accepted.

The length of the sequence follows the operand width parameter `NBITSIN`, which is shared with the square root unit. `NBITSIN` must be even and lie in the range 4 to 64, and the result has `NBITSIN/2` bits, so there are `NBITSIN/2` iteration cycles. Requests that arrive while an operation is in progress are dropped, not queued.

Top module: `sqrt_seq_ctrl`

## Requirements
- R1: While `rst` is high, and in every cycle after reset until the first accepted `run`, `start`, `stop` and `busy` are all low. A `run` sampled while `rst` is high has no effect.
- R2: A `run` sampled high at a rising edge while `busy` is low makes `start` high for exactly the following clock cycle.
- R3: After the `start` cycle there follow exactly `NBITSIN/2` cycles in which `start` and `stop` are both low and `busy` is high.
- R4: `stop` is high for exactly one cycle, the one that immediately follows the last iteration cycle.
- R5: `busy` rises in the same cycle as `start`, stays high through the `stop` cycle, and is low in the cycle after `stop`.
- R6: A `run` sampled while `busy` is high is ignored: no extra `start` follows, and the timing of the operation in progress does not change.
- R7: `start` and `stop` are never high in the same cycle.
- R8: A `run` sampled in the first cycle after `busy` falls starts a new operation, so `run` held high produces back-to-back operations with one idle cycle between them.
- R9: A reset asserted in any phase of an operation returns the block to idle, with all three outputs low in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Request pulse that launches one calculation |
| start | output | 1 | One-cycle strobe that captures the operand in the unit |
| stop | output | 1 | One-cycle strobe that loads the result register |
| busy | output | 1 | High from the `start` cycle through the `stop` cycle |

## Verification
The assertions assume that `run` is a clean synchronous level and that `NBITSIN` is even and within its legal range. Under those conditions `start` can only follow a `run` seen while idle, and every `stop` must land exactly `NBITSIN/2 + 1` cycles after its `start`. The stimulus drives `run` only on falling clock edges. It sweeps a second request across every cycle offset of an operation, holds `run` high continuously, and asserts reset in each phase. All of this keeps inside those assumptions while reaching every ignore and acceptance boundary.

// File: rtl/sqrt_seq_pkg.sv
package sqrt_seq_pkg;

    // Phases of one square root operation
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LAUNCH = 2'd1,
        PH_ITER   = 2'd2,
        PH_LOAD   = 2'd3
    } seq_phase_e;

    // Registered state of the sequencer, outputs kept as flops
    typedef struct packed {
        seq_phase_e phase;
        logic       start;
        logic       stop;
        logic       busy;
    } seq_state_t;

endpackage

// File: rtl/sqrt_seq_cnt.sv
// Down counter that measures the iteration window
module sqrt_seq_cnt #(
    parameter int NITER = 16,
    localparam int CW   = $clog2(NITER + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic last
);

    typedef struct packed {
        logic [CW-1:0] val;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.val = CW'(NITER - 1);
        end else if (dec && (cnt_q.val != '0)) begin
            cnt_d.val = cnt_q.val - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q.val == '0);

endmodule

// File: rtl/sqrt_seq_fsm.sv
// Phase sequencing with registered strobes
module sqrt_seq_fsm
    import sqrt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic last,
    output logic load,
    output logic dec,
    output logic start,
    output logic stop,
    output logic busy
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE:   if (run) st_d.phase = PH_LAUNCH;
            PH_LAUNCH: st_d.phase = PH_ITER;
            PH_ITER:   if (last) st_d.phase = PH_LOAD;
            PH_LOAD:   st_d.phase = PH_IDLE;
            default:   st_d.phase = PH_IDLE;
        endcase
        st_d.start = (st_d.phase == PH_LAUNCH);
        st_d.stop  = (st_d.phase == PH_LOAD);
        st_d.busy  = (st_d.phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, start: 1'b0, stop: 1'b0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign load  = (st_q.phase == PH_LAUNCH);
    assign dec   = (st_q.phase == PH_ITER);
    assign start = st_q.start;
    assign stop  = st_q.stop;
    assign busy  = st_q.busy;

endmodule

// File: rtl/sqrt_seq_ctrl.sv
// Top: sequencer for an iterative square root unit
module sqrt_seq_ctrl #(
    parameter int NBITSIN = 32,
    localparam int NITER  = NBITSIN / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic start,
    output logic stop,
    output logic busy
);

    logic cnt_load;
    logic cnt_dec;
    logic cnt_last;

    sqrt_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .last  (cnt_last),
        .load  (cnt_load),
        .dec   (cnt_dec),
        .start (start),
        .stop  (stop),
        .busy  (busy)
    );

    sqrt_seq_cnt #(
        .NITER (NITER)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_load),
        .dec  (cnt_dec),
        .last (cnt_last)
    );

endmodule

// File: rtl/sqrt_seq_ctrl_chk.sv
// Protocol checker bound to the sequencer top
module sqrt_seq_ctrl_chk #(
    parameter int NITER = 16,
    localparam int KW   = $clog2(NITER + 3)
) (
    input logic clk,
    input logic rst,
    input logic run,
    input logic start,
    input logic stop,
    input logic busy
);

    // Cycles elapsed since the last start, counted independently
    logic [KW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (start) begin
            since_q <= KW'(1);
        end else if (busy) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r2_start_follows_run: assert property (@(posedge clk) disable iff (rst)
        (run && !busy) |=> start);

    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    a_r6_start_needs_idle_run: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(run && !busy));

    a_r5_busy_with_start: assert property (@(posedge clk) disable iff (rst)
        start |-> busy);

    a_r5_busy_with_stop: assert property (@(posedge clk) disable iff (rst)
        stop |-> busy);

    a_r5_busy_falls_after_stop: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !stop));

    a_r4_stop_position: assert property (@(posedge clk) disable iff (rst)
        stop |-> (since_q == KW'(NITER + 1)));

    a_r3_iter_window: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !stop) |-> (since_q <= KW'(NITER)));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start && stop));

endmodule

bind sqrt_seq_ctrl sqrt_seq_ctrl_chk #(.NITER(NITER)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .start (start),
    .stop  (stop),
    .busy  (busy)
);

// File: tb/sqrt_seq_ctrl_tb.sv
module sqrt_seq_ctrl_tb;

    localparam int PERIOD = 10;
    localparam int NB     = 8;
    localparam int NIT    = NB / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic start, stop, busy;

    int checks = 0;
    int errors = 0;
    int phase  = -1;   // -1 idle, 0 start cycle, 1..NIT iterate, NIT+1 stop
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sqrt_seq_ctrl #(.NBITSIN(NB)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .start (start),
        .stop  (stop),
        .busy  (busy)
    );

    task automatic chk(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (phase %0d)", tag, name, act, exp, phase);
        end
    endtask

    // Drive one cycle: inputs set at negedge, model advanced per the rules, outputs compared
    task automatic step(input logic r, input logic rs, input string tag);
        run = r;
        rst = rs;
        @(posedge clk);
        if (rs) phase = -1;
        else if (phase == -1) phase = r ? 0 : -1;
        else if (phase < NIT + 1) phase++;
        else phase = -1;
        @(negedge clk);
        chk(tag, "start", start, phase == 0);
        chk(tag, "stop",  stop,  phase == NIT + 1);
        chk(tag, "busy",  busy,  phase >= 0);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, "R5");
    endtask

    initial begin
        @(negedge clk);
        // R1: reset held, with run high during reset ignored
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R1");

        // R2 R3 R4 R5: a single operation
        step(1'b1, 1'b0, "R2");
        for (int i = 0; i < NIT + 4; i++) step(1'b0, 1'b0, "R3");

        // R6 R8: a second request swept across every offset of an operation
        for (int d = 1; d <= NIT + 4; d++) begin
            step(1'b1, 1'b0, "R2");
            for (int k = 1; k < d; k++) step(1'b0, 1'b0, "R4");
            step(1'b1, 1'b0, (d <= NIT + 2) ? "R6" : "R8");
            settle(2 * NIT + 6);
        end

        // R8: run held high produces back-to-back operations
        for (int i = 0; i < 4 * (NIT + 3); i++) step(1'b1, 1'b0, "R8");
        settle(NIT + 4);

        // R7: start/stop exclusivity is covered by every step above; one more operation
        step(1'b1, 1'b0, "R7");
        settle(NIT + 3);

        // R9: reset in each phase of an operation
        for (int p = 0; p <= NIT + 1; p++) begin
            step(1'b1, 1'b0, "R9");
            for (int k = 0; k < p; k++) step(1'b0, 1'b0, "R9");
            step(1'b0, 1'b1, "R9");
            step(1'b0, 1'b0, "R9");
            settle(2);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule